// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a reference clock into the 16x oversampling strobe that a UART serializer and sampler run from. The divisor has two parts: a 16-bit whole part and a 6-bit fraction in sixty-fourths. Software chooses the divisor as reference_clock × 64 / (16 × baud), so that the strobe rate is sixteen times the line rate. The largest divisor is 65535 + 63/64. A divisor of exactly 1.0 gives one strobe on every reference clock.

Software writes the whole part and the fraction into two separate holding registers. Neither holding register changes the running divisor. Only a line-control write moves both parts into the running divisor, and it moves them together. This rule means that a half-updated divisor never reaches the counter.

A down-count measures each oversample period. A 6-bit accumulator adds the fraction once per period. When that sum wraps past 63, the period gets one extra reference clock. Because of this dithering, the average period equals the programmed divisor exactly. A valid output reports whether the running divisor is usable. A running divisor whose whole part is zero is treated as invalid and produces no strobe.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the running divisor is zero, so `div_valid` is low and `os_tick` is low.
- R2: Writes to the whole-part or fraction holding registers have no effect on the strobe spacing until a line-control write (`lcr_wr`) occurs.
- R3: A line-control write copies both holding registers into the running divisor on the same clock edge. The values copied are those held before that edge. A holding-register write in the same cycle as the line-control write is taken only by a later line-control write.
- R4: A running divisor with a whole part of 0 is invalid. While it is running, `div_valid` is low and `os_tick` never pulses. Any whole part from 1 to 65535, with any fraction, is valid.
- R5: A running divisor of 1.0 (whole part 1, fraction 0) with `uart_en` high gives `os_tick` high on every cycle.
- R6: Every oversample period with whole part I lasts either I or I+1 reference clocks. It lasts I+1 exactly when adding the fraction to the 6-bit accumulator at the end of that period carries out of bit 5.
- R7: For whole part I and fraction F, the first 64 periods after a line-control write span exactly 64·I + F reference clocks. The average period therefore matches I + F/64 to well within one clock.
- R8: After a line-control write edge, or after the first enabled edge that follows `uart_en` being low, the first `os_tick` comes in the I-th cycle. The period counter and the accumulator both restart from zero at that point.
- R9: While `uart_en` is low, `os_tick` stays low, and `div_valid` still shows the state of the running divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uart_en | input | 1 | UART enable; low stops the strobe and clears the period counter and the accumulator |
| whole_wr | input | 1 | Write strobe for the whole-part holding register |
| whole_wdata | input | 16 | Whole part of the divisor |
| frac_wr | input | 1 | Write strobe for the fraction holding register |
| frac_wdata | input | 6 | Fraction of the divisor, in sixty-fourths |
| lcr_wr | input | 1 | Line-control write strobe; copies the holding registers into the running divisor |
| os_tick | output | 1 | One-cycle oversample strobe at 16 times the baud rate |
| div_valid | output | 1 | High while the running divisor is usable |

## Verification
A wrong accumulator or carry decision does not always show in a single period. It always shows in the total length of 64 consecutive periods, because that total must equal 64·I + F exactly. A wrong carry can therefore stay hidden for up to 63 periods, and it is caught at the end of the 64-period window. A counter that is not cleared on a latch or on re-enable shows at once: the first strobe arrives in the wrong cycle. A holding register that leaks into the running divisor changes the spacing of the very next period.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  parameter int FBG_WHOLE_W = 16;
  parameter int FBG_FRAC_W  = 6;
endpackage

// File: rtl/fbg_div_regs.sv
module fbg_div_regs #(
  parameter int IW = fbg_pkg::FBG_WHOLE_W,
  parameter int FW = fbg_pkg::FBG_FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          whole_wr,
  input  logic [IW-1:0] whole_wdata,
  input  logic          frac_wr,
  input  logic [FW-1:0] frac_wdata,
  input  logic          lcr_wr,
  output logic [IW-1:0] hold_whole,
  output logic [FW-1:0] hold_frac,
  output logic [IW-1:0] run_whole,
  output logic [FW-1:0] run_frac
);
  // holding registers: software-visible, never drive the counter directly
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_whole <= '0;
      hold_frac  <= '0;
    end else begin
      if (whole_wr) hold_whole <= whole_wdata;
      if (frac_wr)  hold_frac  <= frac_wdata;
    end
  end

  // running divisor: both parts move together on a line-control write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_whole <= '0;
      run_frac  <= '0;
    end else if (lcr_wr) begin
      run_whole <= hold_whole;
      run_frac  <= hold_frac;
    end
  end
endmodule

// File: rtl/fbg_frac_acc.sv
module fbg_frac_acc #(
  parameter int FW = fbg_pkg::FBG_FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  input  logic [FW-1:0] frac,
  output logic [FW-1:0] acc,
  output logic          carry
);
  // sum of accumulator and fraction, one bit wider to expose the carry
  function automatic logic [FW:0] frac_sum(input logic [FW-1:0] a, input logic [FW-1:0] f);
    return {1'b0, a} + {1'b0, f};
  endfunction

  logic [FW:0] sum_w;
  assign sum_w = frac_sum(acc, frac);
  assign carry = sum_w[FW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (clear)   acc <= '0;
    else if (advance) acc <= sum_w[FW-1:0];
  end
endmodule

// File: rtl/fbg_period_cnt.sv
module fbg_period_cnt #(
  parameter int IW = fbg_pkg::FBG_WHOLE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic [IW-1:0] whole,
  input  logic          extend,
  output logic [IW-1:0] cnt,
  output logic          period_end
);
  // index of the last cycle of the current period: whole - 1 + extend
  function automatic logic [IW:0] last_index(input logic [IW-1:0] w, input logic e);
    return {1'b0, w} - {{IW{1'b0}}, 1'b1} + {{IW{1'b0}}, e};
  endfunction

  logic [IW:0] last_w;
  assign last_w     = last_index(whole, extend);
  assign period_end = run && ({1'b0, cnt} == last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (period_end) cnt <= '0;
    else if (run)        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int IW = fbg_pkg::FBG_WHOLE_W,
  parameter int FW = fbg_pkg::FBG_FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          uart_en,
  input  logic          whole_wr,
  input  logic [IW-1:0] whole_wdata,
  input  logic          frac_wr,
  input  logic [FW-1:0] frac_wdata,
  input  logic          lcr_wr,
  output logic          os_tick,
  output logic          div_valid
);
  logic [IW-1:0] hold_whole, run_whole, cnt_q;
  logic [FW-1:0] hold_frac, run_frac, acc_q;
  logic          div_ok, run_en, restart, carry_w, period_end;

  fbg_div_regs #(.IW(IW), .FW(FW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .whole_wr(whole_wr), .whole_wdata(whole_wdata),
    .frac_wr(frac_wr), .frac_wdata(frac_wdata),
    .lcr_wr(lcr_wr),
    .hold_whole(hold_whole), .hold_frac(hold_frac),
    .run_whole(run_whole), .run_frac(run_frac)
  );

  // a zero whole part is the only reachable out-of-range value at this width
  assign div_ok  = (run_whole != '0);
  assign run_en  = uart_en && div_ok;
  assign restart = lcr_wr || !uart_en;

  fbg_frac_acc #(.FW(FW)) acc_i (
    .clk(clk), .rst_n(rst_n),
    .clear(restart), .advance(period_end),
    .frac(run_frac), .acc(acc_q), .carry(carry_w)
  );

  fbg_period_cnt #(.IW(IW)) cnt_i (
    .clk(clk), .rst_n(rst_n),
    .clear(restart), .run(run_en),
    .whole(run_whole), .extend(carry_w),
    .cnt(cnt_q), .period_end(period_end)
  );

  assign os_tick   = period_end;
  assign div_valid = div_ok;
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int IW = 16,
  parameter int FW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          uart_en,
  input logic          lcr_wr,
  input logic          os_tick,
  input logic          div_valid,
  input logic [IW-1:0] hold_whole,
  input logic [FW-1:0] hold_frac,
  input logic [IW-1:0] run_whole,
  input logic [FW-1:0] run_frac,
  input logic [IW-1:0] cnt_q,
  input logic [FW-1:0] acc_q
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !div_valid); // R1
  AST_RUN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lcr_wr |=> $stable(run_whole) && $stable(run_frac)); // R2
  AST_LATCH_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_wr |=> (run_whole == $past(hold_whole)) && (run_frac == $past(hold_frac))); // R3
  AST_NO_TICK_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !div_valid |-> !os_tick); // R4
  AST_UNIT_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_en && run_whole == 1 && run_frac == 0) |-> os_tick); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= run_whole); // R6
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_wr || !uart_en) |=> (cnt_q == 0) && (acc_q == 0)); // R8
  AST_NO_TICK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_en |-> !os_tick); // R9
endmodule

bind frac_baud_gen fbg_checker #(.IW(IW), .FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .lcr_wr(lcr_wr),
  .os_tick(os_tick), .div_valid(div_valid),
  .hold_whole(hold_whole), .hold_frac(hold_frac),
  .run_whole(run_whole), .run_frac(run_frac),
  .cnt_q(cnt_q), .acc_q(acc_q)
);

// File: tb/frac_baud_gen_tb_top.sv
module frac_baud_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        uart_en = 1'b0;
  logic        whole_wr = 1'b0;
  logic [15:0] whole_wdata = '0;
  logic        frac_wr = 1'b0;
  logic [5:0]  frac_wdata = '0;
  logic        lcr_wr = 1'b0;
  logic        os_tick, div_valid;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  frac_baud_gen dut_i (
    .clk(clk), .rst_n(rst_n), .uart_en(uart_en),
    .whole_wr(whole_wr), .whole_wdata(whole_wdata),
    .frac_wr(frac_wr), .frac_wdata(frac_wdata),
    .lcr_wr(lcr_wr), .os_tick(os_tick), .div_valid(div_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_whole(input int v);
    @(negedge clk); whole_wr = 1'b1; whole_wdata = v[15:0];
    @(negedge clk); whole_wr = 1'b0;
  endtask

  task automatic put_frac(input int v);
    @(negedge clk); frac_wr = 1'b1; frac_wdata = v[5:0];
    @(negedge clk); frac_wr = 1'b0;
  endtask

  // returns at the first negedge after the latch edge (cycle 1)
  task automatic do_latch();
    @(negedge clk); lcr_wr = 1'b1;
    @(negedge clk); lcr_wr = 1'b0;
  endtask

  // current negedge is cycle 1 of a fresh run; check 64 periods
  task automatic measure(input int iw, input int fr, input string req);
    int c = 0, n = 0, first = 0, prev = 0, bad_gap = 0;
    while (n < 64 && c < 50000) begin
      c++;
      if (os_tick) begin
        n++;
        if (n == 1) first = c;
        else if ((c - prev) != iw && (c - prev) != iw + 1) bad_gap = c - prev;
        prev = c;
      end
      if (n < 64) @(negedge clk);
    end
    check(first == iw, {req, " R8 first tick"}, first, iw);
    check(bad_gap == 0, {req, " R6 period length"}, bad_gap, iw);
    check(c == 64 * iw + fr, {req, " R7 64-period span"}, c, 64 * iw + fr);
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (os_tick) n++;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int wl[5];
    int fl[5];
    int n;
    wl = '{1, 2, 3, 7, 300};
    fl = '{0, 1, 31, 32, 63};
    repeat (3) @(negedge clk);
    check(div_valid == 1'b0, "R1 valid after reset", div_valid, 0);
    check(os_tick == 1'b0, "R1 tick after reset", os_tick, 0);
    rst_n = 1'b1;
    uart_en = 1'b1;
    count_ticks(20, n);
    check(n == 0, "R1 no tick before first latch", n, 0);

    // R5: unit divisor
    put_whole(1); put_frac(0); do_latch();
    check(div_valid == 1'b1, "R5 valid", div_valid, 1);
    count_ticks(30, n);
    check(n == 30, "R5 tick every cycle", n, 30);

    // R6/R7/R8 sweep
    foreach (wl[i]) begin
      foreach (fl[j]) begin
        if (wl[i] != 300 || j == 4) begin
          put_whole(wl[i]); put_frac(fl[j]); do_latch();
          measure(wl[i], fl[j], $sformatf("sweep %0d+%0d/64", wl[i], fl[j]));
        end
      end
    end

    // R2: staged writes without a latch leave spacing alone
    put_whole(3); put_frac(0); do_latch();
    put_whole(9); put_frac(40);
    @(negedge clk); uart_en = 1'b0;
    @(negedge clk);
    check(os_tick == 1'b0, "R9 no tick while disabled", os_tick, 0);
    check(div_valid == 1'b1, "R9 valid while disabled", div_valid, 1);
    count_ticks(40, n);
    check(n == 0, "R9 disabled tick count", n, 0);
    @(negedge clk); uart_en = 1'b1;
    measure(3, 0, "R2 staged not applied");
    do_latch();
    measure(9, 40, "R2 staged applied on latch");

    // R3: holding write in the latch cycle goes to the next latch
    put_whole(2); put_frac(0);
    @(negedge clk); whole_wr = 1'b1; whole_wdata = 16'd5; lcr_wr = 1'b1;
    @(negedge clk); whole_wr = 1'b0; lcr_wr = 1'b0;
    measure(2, 0, "R3 same-cycle write");
    do_latch();
    measure(5, 0, "R3 next latch");

    // R4: zero whole part is invalid, max divisor is valid
    put_whole(0); put_frac(17); do_latch();
    check(div_valid == 1'b0, "R4 zero invalid", div_valid, 0);
    count_ticks(200, n);
    check(n == 0, "R4 no tick when invalid", n, 0);
    put_whole(65535); put_frac(63); do_latch();
    check(div_valid == 1'b1, "R4 max divisor valid", div_valid, 1);
    count_ticks(200, n);
    check(n == 0, "R4 max divisor long period", n, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule